// File: doc/BRIEF.md
# Banked RAM Address Mapper

This block sits between an 8-bit processor and a 128 KB RAM built from eight 16 KB physical blocks. Blocks 0 to 3 make up the base bank and blocks 4 to 7 the expansion bank. The processor's 64 KB address space is split into four 16 KB quadrants. A small configuration register selects one of eight fixed maps, and each map assigns every quadrant to one physical block. The processor's 16-bit address is turned into a 17-bit physical address through the selected map.

The configuration register is loaded by a processor I/O write whose upper address byte matches a fixed port value. A second translation path serves the video fetch unit. It ignores the banking and always points into the base 64 KB. Software can therefore page the expansion blocks, or re-expose a base block at another window, without disturbing what the display reads.

Top module: `bank_mapper`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted write, the map is configuration 0, in which quadrants 0, 1, 2 and 3 (cpu_addr[15:14]) use blocks 0, 1, 2 and 3.
- R2: A write is accepted when io_wr is high at a rising clock edge, cpu_addr[15:8] equals 0x7F and data_in[7:6] equals 0b11. Any value of cpu_addr[7:0] is accepted. data_in[2:0] becomes the configuration at that edge and applies to every address presented after it.
- R3: An I/O write whose cpu_addr[15:8] is not 0x7F leaves the configuration unchanged.
- R4: An I/O write whose data_in[7:6] is not 0b11 leaves the configuration unchanged. data_in[5:3] has no effect on the selected map.
- R5: Configuration 1 maps quadrants 0 to 3 onto blocks 0, 1, 2 and 7.
- R6: Configuration 2 maps quadrants 0 to 3 onto blocks 4, 5, 6 and 7.
- R7: Configuration 3 maps quadrants 0 to 3 onto blocks 0, 3, 2 and 7, so processor address 0x4000 reaches physical 0x0C000.
- R8: Configurations 4, 5, 6 and 7 place block 4, 5, 6 or 7 in quadrant 1. Quadrants 0, 2 and 3 keep blocks 0, 2 and 3.
- R9: cpu_phys is {block, cpu_addr[13:0]} and follows cpu_addr combinationally.
- R10: vid_phys is {1'b0, vid_addr} under every configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address; also the I/O port number during io_wr |
| io_wr | input | 1 | Processor I/O write strobe |
| data_in | input | 8 | Processor data bus |
| vid_addr | input | 16 | Video fetch address |
| cpu_phys | output | 17 | Physical RAM address for the processor |
| vid_phys | output | 17 | Physical RAM address for video |

## Verification
Both translated addresses are combinational from the current inputs and the registered configuration. They are therefore due in the same cycle that an address is presented. A configuration write becomes visible at the rising edge that samples the strobe. The bench drives each address just after a rising edge and compares it at the following falling edge. Expected items from the driver are queued in order, so the monitor always pairs the outputs with the stimulus of the half cycle just elapsed, and every map change lies at least one full edge before the addresses that depend on it.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int QUAD_W  = 2;
  localparam int BLOCK_W = 3;
  localparam int SEL_W   = 3;

  typedef logic [BLOCK_W-1:0] block_t;
  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [QUAD_W-1:0]  quad_t;

  // Quadrant-to-block table for the eight fixed configurations.
  function automatic block_t quad_block(input sel_t sel, input quad_t q);
    block_t b;
    b = {1'b0, q};
    case (sel)
      3'd0: b = {1'b0, q};
      3'd1: b = (q == 2'd3) ? 3'd7 : {1'b0, q};
      3'd2: b = {1'b1, q};
      3'd3: begin
        if (q == 2'd1)      b = 3'd3;
        else if (q == 2'd3) b = 3'd7;
        else                b = {1'b0, q};
      end
      default: b = (q == 2'd1) ? {1'b1, sel[1:0]} : {1'b0, q};
    endcase
    return b;
  endfunction
endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg
  import bank_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  PORT_HI = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] data_in,
  output sel_t              sel_q
);
  localparam int HI_W = ADDR_W - 8;

  logic port_hit;
  logic tag_ok;
  logic load_en;
  sel_t sel_d;

  always_comb begin
    port_hit = (cpu_addr[ADDR_W-1 -: HI_W] == PORT_HI[HI_W-1:0]);
    tag_ok   = (data_in[DATA_W-1 -: 2] == 2'b11);
    load_en  = io_wr && port_hit && tag_ok;
    sel_d    = data_in[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (load_en) sel_q <= sel_d;
  end

  // R2: accepted write loads the low data bits
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && cpu_addr[ADDR_W-1 -: HI_W] == PORT_HI[HI_W-1:0] && data_in[DATA_W-1 -: 2] == 2'b11)
      |=> sel_q == $past(data_in[SEL_W-1:0]));

  // R3: other port numbers do not touch the configuration
  a_r3_wrong_port: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && cpu_addr[ADDR_W-1 -: HI_W] != PORT_HI[HI_W-1:0]) |=> $stable(sel_q));

  // R4: a bad tag in the top data bits is ignored
  a_r4_bad_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && data_in[DATA_W-1 -: 2] != 2'b11) |=> $stable(sel_q));

  // R1: no change without a strobe
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(sel_q));
endmodule

// File: rtl/bank_map.sv
module bank_map
  import bank_pkg::*;
#(
  parameter int NQUAD = 4
) (
  input  sel_t   sel,
  output block_t blocks [NQUAD]
);
  for (genvar q = 0; q < NQUAD; q++) begin : g_quad
    always_comb blocks[q] = quad_block(sel, quad_t'(q));
  end
endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NQUAD  = 4
) (
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  block_t                    blocks [NQUAD],
  input  logic [ADDR_W-1:0]         vid_addr,
  output logic [ADDR_W+BLOCK_W-QUAD_W-1:0] cpu_phys,
  output logic [ADDR_W+BLOCK_W-QUAD_W:0]   vid_phys
);
  localparam int OFFS_W = ADDR_W - QUAD_W;
  localparam int VPAD_W = BLOCK_W - QUAD_W;

  quad_t  quad;
  block_t blk;

  always_comb begin
    quad     = cpu_addr[ADDR_W-1 -: QUAD_W];
    blk      = blocks[quad];
    cpu_phys = {blk, cpu_addr[OFFS_W-1:0]};
    vid_phys = {{VPAD_W{1'b0}}, 1'b0, vid_addr};
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_pkg::*;
#(
  parameter int         ADDR_W  = 16,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] PORT_HI = 8'h7F,
  parameter int         SYNC_ST = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic                 io_wr,
  input  logic [DATA_W-1:0]    data_in,
  input  logic [ADDR_W-1:0]    vid_addr,
  output logic [ADDR_W:0]      cpu_phys,
  output logic [ADDR_W:0]      vid_phys
);
  localparam int NQUAD = 1 << QUAD_W;

  logic   rst_sync_n;
  sel_t   sel_q;
  block_t blocks [NQUAD];
  logic [ADDR_W+BLOCK_W-QUAD_W-1:0] cpu_full;
  logic [ADDR_W+BLOCK_W-QUAD_W:0]   vid_full;

  bank_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  bank_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_HI(PORT_HI)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
    .data_in(data_in), .sel_q(sel_q));

  bank_map #(.NQUAD(NQUAD)) u_map (.sel(sel_q), .blocks(blocks));

  bank_xlate #(.ADDR_W(ADDR_W), .NQUAD(NQUAD)) u_xl (
    .cpu_addr(cpu_addr), .blocks(blocks), .vid_addr(vid_addr),
    .cpu_phys(cpu_full), .vid_phys(vid_full));

  assign cpu_phys = cpu_full[ADDR_W:0];
  assign vid_phys = vid_full[ADDR_W:0];

  // R1: default map is identity
  a_r1_default: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_q == 3'd0 |-> cpu_phys[ADDR_W:ADDR_W-2] == {1'b0, cpu_addr[ADDR_W-1 -: 2]});
  // R5: top quadrant shows the last expansion block
  a_r5_top_ext: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_q == 3'd1 && cpu_addr[ADDR_W-1 -: 2] == 2'd3) |-> cpu_phys[ADDR_W:ADDR_W-2] == 3'd7);
  // R6: full swap reaches only the expansion bank
  a_r6_full_swap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_q == 3'd2 |-> cpu_phys[ADDR_W]);
  // R7: base top block aliased into quadrant 1
  a_r7_alias: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_q == 3'd3 && cpu_addr[ADDR_W-1 -: 2] == 2'd1) |-> cpu_phys[ADDR_W:ADDR_W-2] == 3'd3);
  // R8: window configurations only move quadrant 1
  a_r8_window: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_q[2] && cpu_addr[ADDR_W-1 -: 2] != 2'd1) |-> !cpu_phys[ADDR_W]);
  // R9: offset passes through
  a_r9_offset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_phys[ADDR_W-3:0] == cpu_addr[ADDR_W-3:0]);
  // R10: video never reaches the expansion bank
  a_r10_video: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !vid_phys[ADDR_W]);
endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  localparam int P = 10;

  typedef struct {
    logic [16:0] cpu_exp;
    logic [16:0] vid_exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        io_wr;
  logic [7:0]  data_in;
  logic [15:0] vid_addr;
  logic [16:0] cpu_phys;
  logic [16:0] vid_phys;

  int   n_chk = 0;
  int   n_bad = 0;
  logic [2:0] exp_sel;
  item_t q[$];

  always #(P/2) clk = ~clk;

  bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
    .data_in(data_in), .vid_addr(vid_addr), .cpu_phys(cpu_phys), .vid_phys(vid_phys));

  function automatic logic [2:0] model_blk(logic [2:0] s, logic [1:0] qd);
    case (s)
      3'd0: return {1'b0, qd};
      3'd1: return (qd == 2'd3) ? 3'd7 : {1'b0, qd};
      3'd2: return {1'b1, qd} ;
      3'd3: return (qd == 2'd1) ? 3'd3 : ((qd == 2'd3) ? 3'd7 : {1'b0, qd});
      default: return (qd == 2'd1) ? (3'd4 + {1'b0, s[1:0]}) : {1'b0, qd};
    endcase
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] v, input string req);
    item_t it;
    @(posedge clk); #1;
    cpu_addr = a; vid_addr = v; io_wr = 1'b0;
    it.cpu_exp = {model_blk(exp_sel, a[15:14]), a[13:0]};
    it.vid_exp = {1'b0, v};
    it.req = req;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic write_cfg(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = {hi, lo}; data_in = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
    if (hi == 8'h7F && d[7:6] == 2'b11) exp_sel = d[2:0];
  endtask

  task automatic sweep(input string req, input logic [15:0] seed);
    for (int k = 0; k < 4; k++) begin
      logic [15:0] a;
      a = {k[1:0], seed[13:0] ^ 14'(k * 16'h0A53)};
      apply(a, seed ^ 16'(k * 16'h3C11), req);
    end
  endtask

  // monitor: compare at falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk += 2;
      if (cpu_phys !== it.cpu_exp) begin
        n_bad++;
        $display("FAIL %s cpu_phys actual %05h expected %05h", it.req, cpu_phys, it.cpu_exp);
      end
      if (vid_phys !== it.vid_exp) begin
        n_bad++;
        $display("FAIL R10 vid_phys actual %05h expected %05h", vid_phys, it.vid_exp);
      end
    end
  end

  initial begin
    #(P * 100000);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = '0; io_wr = 1'b0; data_in = '0; vid_addr = '0;
    exp_sel = 3'd0;
    sweep("R1", 16'h1234);             // reset state
    #3 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    sweep("R1", 16'h5A5A);
    // each configuration, varied low port byte, bits 5:3 junk (R2, R4)
    write_cfg(8'h7F, 8'h00, 8'hC1); sweep("R5", 16'h0F0F);
    write_cfg(8'h7F, 8'hFF, 8'hEA); sweep("R6", 16'h7777);
    write_cfg(8'h7F, 8'h3C, 8'hC3); sweep("R7", 16'h0000);
    apply(16'h4000, 16'hC000, "R7");   // 0x4000 -> 0x0C000
    write_cfg(8'h7F, 8'h81, 8'hC4); sweep("R8", 16'h2468);
    write_cfg(8'h7F, 8'h42, 8'hD5); sweep("R8", 16'h1357);
    write_cfg(8'h7F, 8'h10, 8'hC6); sweep("R8", 16'h3FFF);
    write_cfg(8'h7F, 8'h99, 8'hFF); sweep("R8", 16'hABCD);
    write_cfg(8'h7F, 8'h07, 8'hC0); sweep("R2", 16'h1111);
    // R9: offset extremes
    write_cfg(8'h7F, 8'h55, 8'hC2);
    apply(16'h3FFF, 16'hFFFF, "R9");
    apply(16'hC000, 16'h0000, "R9");
    // R3: wrong port number, config stays at 2
    write_cfg(8'h7E, 8'h00, 8'hC0); sweep("R3", 16'h2222);
    write_cfg(8'hFF, 8'h00, 8'hC1); sweep("R3", 16'h3333);
    // R4: bad tag bits, config stays at 2
    write_cfg(8'h7F, 8'h00, 8'h80); sweep("R4", 16'h4444);
    write_cfg(8'h7F, 8'h00, 8'h43); sweep("R4", 16'h5555);
    // R4: bits 5:3 differ but same map
    write_cfg(8'h7F, 8'h00, 8'hF9); sweep("R4", 16'h6666);
    // R1: reset again returns to default
    write_cfg(8'h7F, 8'h00, 8'hC2);
    @(negedge clk); rst_n = 1'b0; exp_sel = 3'd0;
    sweep("R1", 16'h7E7E);
    #3 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    sweep("R1", 16'h0101);
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule